// File: doc/BRIEF.md
# Gap-Aware Scoring Cell for Approximate Subsequence Tokens

This block is one cell of a two-dimensional array that searches for the longest common subsequence of two symbol strings while tolerating gaps. Scoring tokens travel through the array. Each token carries a Length score, which counts matched symbols, and a Gap score, which counts gap positions that were crossed. A token can reach the cell from its South neighbour, from its East neighbour, or from both in the same cycle.

When tokens arrive, the cell first picks one winner. The higher Length wins. If the Lengths are equal, the lower Gap wins. If both scores are equal, the South token is taken. The cell then scores the winner using its own two flags. The match flag adds one to Length. The gap-crossing flag, which is set where vertical and horizontal bypasses both span a non-matching position, adds one to Gap. Both scores saturate. Finally the cell looks at its West–South bypass:

- If the bypass is closed, the scored token leaves on the forward output one cycle later.
- If the bypass is open, the cell is the end of a chain. The scored token competes with the best result held in the cell under the same ordering, and is kept only if it ranks higher.

A clear pulse empties the held result.

Top module: `lcs_gap_cell`

## Requirements
- R1: After reset, and during reset, `fwd_valid` and `best_valid` are 0, and `fwd_len`, `fwd_gap`, `best_len` and `best_gap` are 0.
- R2: A forwarded token shows on `fwd_*` in the cycle after its arrival. Its Length is the arriving Length plus 1 when `match_i` is 1, and is unchanged when `match_i` is 0.
- R3: The forwarded Gap is the arriving Gap plus 1 when `gap_i` is 1, and is unchanged when `gap_i` is 0. The two flags act independently.
- R4: Length and Gap are 8-bit counts that saturate at 255. An increment of 255 yields 255.
- R5: When both ports carry a valid token, the token with the larger Length is the one that is scored and forwarded or stored.
- R6: When both valid tokens have equal Length, the token with the smaller Gap wins. If Length and Gap are both equal, the South token is taken.
- R7: A port whose valid bit is 0 takes no part. Its Length and Gap have no effect on the result.
- R8: With `bypass_ws_i`=1 a winning token is forwarded and the held result is unchanged. With `bypass_ws_i`=0 nothing is forwarded (`fwd_valid`=0 next cycle) and the scored token is offered to the held result.
- R9: A token offered to the held result replaces it only if the held result is empty or the token ranks higher by the R5/R6 ordering. Otherwise the held result is unchanged.
- R10: `clear_i`=1 empties the held result in the next cycle. If a token is offered for storage in the same cycle, the held result is loaded with that token instead, with no comparison against the old value.
- R11: With no valid arriving token, `fwd_valid` is 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| s_valid | input | 1 | South token present |
| s_len | input | 8 | South token Length |
| s_gap | input | 8 | South token Gap |
| e_valid | input | 1 | East token present |
| e_len | input | 8 | East token Length |
| e_gap | input | 8 | East token Gap |
| match_i | input | 1 | Cell symbols match; adds 1 to Length |
| gap_i | input | 1 | Cell is a spanned gap position; adds 1 to Gap |
| bypass_ws_i | input | 1 | West–South bypass closed: forward instead of store |
| clear_i | input | 1 | Empty the held result |
| fwd_valid | output | 1 | Forwarded token present |
| fwd_len | output | 8 | Forwarded Length |
| fwd_gap | output | 8 | Forwarded Gap |
| best_valid | output | 1 | Held result present |
| best_len | output | 8 | Held result Length |
| best_gap | output | 8 | Held result Gap |

## Verification
Two pairs of events can land in the same cycle.

The first pair is arrivals on both ports. The bench drives South and East tokens together, and orders them so that each of the following holds in turn:
- Length alone decides the winner.
- Gap alone decides the winner.
- The losing side has a large score but its valid bit is low.

For each case the forwarded scores are compared with the winner's scores plus the cell's increments.

The second pair is a clear pulse together with a token that is to be stored. The bench first holds a strong result, then raises `clear_i` in the same cycle as a much weaker stored arrival. It expects the weaker token to be held, because clearing takes precedence over comparison.

// File: rtl/lcs_tok_pkg.sv
// Package: shared token type and ranking function for the gap-aware cell.
// Assumes Length and Gap counts of fixed width set here for the whole array.
package lcs_tok_pkg;

    parameter int TOK_LEN_W = 8;
    parameter int TOK_GAP_W = 8;

    typedef struct packed {
        logic                 valid;
        logic [TOK_LEN_W-1:0] len;
        logic [TOK_GAP_W-1:0] gap;
    } tok_t;

    // True when token x ranks strictly above token y (Length first, then fewer gaps).
    function automatic logic tok_beats(input tok_t x, input tok_t y);
        logic res;
        res = 1'b0;
        if (x.valid) begin
            if (!y.valid)
                res = 1'b1;
            else if (x.len > y.len)
                res = 1'b1;
            else if ((x.len == y.len) && (x.gap < y.gap))
                res = 1'b1;
        end
        return res;
    endfunction

endpackage

// File: rtl/sat_inc.sv
// Module: saturating conditional incrementer.
// Adds one to the input when enabled, holding at the all-ones value.
// Assumes W >= 1; purely combinational.
module sat_inc #(
    parameter int W = 8
) (
    input  logic [W-1:0] val_i,
    input  logic         en_i,
    output logic [W-1:0] val_o
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    // Increment unless disabled or already saturated.
    always_comb begin
        if (en_i && (val_i != TOP))
            val_o = val_i + {{(W-1){1'b0}}, 1'b1};
        else
            val_o = val_i;
    end
endmodule

// File: rtl/tok_arbiter.sv
// Module: two-port token arbiter.
// Picks the higher-ranked of the South and East tokens.
// On a full tie the South token is chosen. Invalid ports never win.
// Purely combinational.
module tok_arbiter
    import lcs_tok_pkg::*;
(
    input  tok_t south_i,
    input  tok_t east_i,
    output tok_t win_o
);
    logic east_wins;

    // East is chosen only when it strictly outranks South.
    always_comb begin
        east_wins = tok_beats(east_i, south_i);
        if (east_wins)
            win_o = east_i;
        else if (south_i.valid)
            win_o = south_i;
        else
            win_o = '0;
    end
endmodule

// File: rtl/tok_scorer.sv
// Module: applies a cell's match and gap flags to a token.
// Length and Gap each step by one, saturating.
// The valid bit passes through unchanged. Combinational.
module tok_scorer
    import lcs_tok_pkg::*;
(
    input  tok_t tok_i,
    input  logic match_i,
    input  logic gap_i,
    output tok_t tok_o
);
    localparam int NCNT = 2;

    logic [NCNT-1:0] en;
    logic [TOK_LEN_W-1:0] len_n;
    logic [TOK_GAP_W-1:0] gap_n;

    // Increments happen only on a live token.
    always_comb begin
        en[0] = tok_i.valid & match_i;
        en[1] = tok_i.valid & gap_i;
    end

    // One saturating counter per score field.
    generate
        for (genvar k = 0; k < NCNT; k++) begin : g_cnt
            if (k == 0) begin : g_len
                sat_inc #(.W(TOK_LEN_W)) u_inc (
                    .val_i (tok_i.len),
                    .en_i  (en[k]),
                    .val_o (len_n)
                );
            end else begin : g_gap
                sat_inc #(.W(TOK_GAP_W)) u_inc (
                    .val_i (tok_i.gap),
                    .en_i  (en[k]),
                    .val_o (gap_n)
                );
            end
        end
    endgenerate

    // Reassemble the scored token.
    always_comb begin
        tok_o.valid = tok_i.valid;
        tok_o.len   = len_n;
        tok_o.gap   = gap_n;
    end
endmodule

// File: rtl/tok_result.sv
// Module: best-so-far result store for a chain-end cell.
// Keeps the highest-ranked offered token. Clear empties the store.
// A token offered together with clear is loaded without comparison.
// Assumes cand_i.valid is high only for tokens meant for storage.
module tok_result
    import lcs_tok_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  tok_t cand_i,
    output tok_t best_o
);
    tok_t best_q;

    // Update the held result: reset, clear-with-load, or keep the better token.
    always_ff @(posedge clk) begin
        if (!rst_n)
            best_q <= '0;
        else if (clear_i)
            best_q <= cand_i.valid ? cand_i : '0;
        else if (tok_beats(cand_i, best_q))
            best_q <= cand_i;
    end

    assign best_o = best_q;

    // R9: a held result is never lost without a clear.
    a_r9_keep_result: assert property (@(posedge clk) disable iff (!rst_n)
        (best_q.valid && !clear_i) |=> best_q.valid);

    // R9: an offer that does not outrank the held result leaves it unchanged.
    a_r9_no_downgrade: assert property (@(posedge clk) disable iff (!rst_n)
        (best_q.valid && !clear_i && !tok_beats(cand_i, best_q)) |=> $stable(best_q));

    // R10: a clear with no offer empties the store.
    a_r10_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_i && !cand_i.valid) |=> !best_q.valid);

    // R10: a clear with an offer loads exactly that offer.
    a_r10_clear_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_i && cand_i.valid) |=> (best_q == $past(cand_i)));
endmodule

// File: rtl/lcs_gap_cell.sv
// Module: gap-aware subsequence token cell (top).
// Arbitrates South/East arrivals, scores the winner with the match and gap
// flags, then either forwards it (bypass closed) or offers it to the
// best-so-far store (bypass open). Forward output is registered, latency 1.
// Assumes synchronous active-low reset and inputs stable around the clock edge.
module lcs_gap_cell
    import lcs_tok_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 s_valid,
    input  logic [TOK_LEN_W-1:0] s_len,
    input  logic [TOK_GAP_W-1:0] s_gap,
    input  logic                 e_valid,
    input  logic [TOK_LEN_W-1:0] e_len,
    input  logic [TOK_GAP_W-1:0] e_gap,
    input  logic                 match_i,
    input  logic                 gap_i,
    input  logic                 bypass_ws_i,
    input  logic                 clear_i,
    output logic                 fwd_valid,
    output logic [TOK_LEN_W-1:0] fwd_len,
    output logic [TOK_GAP_W-1:0] fwd_gap,
    output logic                 best_valid,
    output logic [TOK_LEN_W-1:0] best_len,
    output logic [TOK_GAP_W-1:0] best_gap
);
    localparam logic [TOK_LEN_W-1:0] LEN_MAX = {TOK_LEN_W{1'b1}};

    tok_t tok_s, tok_e, tok_win, tok_scored, tok_store, fwd_q, best_t;

    // Pack the port tokens.
    always_comb begin
        tok_s = '{valid: s_valid, len: s_len, gap: s_gap};
        tok_e = '{valid: e_valid, len: e_len, gap: e_gap};
    end

    tok_arbiter u_arb (
        .south_i (tok_s),
        .east_i  (tok_e),
        .win_o   (tok_win)
    );

    tok_scorer u_score (
        .tok_i   (tok_win),
        .match_i (match_i),
        .gap_i   (gap_i),
        .tok_o   (tok_scored)
    );

    // Route the scored token to the store only when the bypass is open.
    always_comb begin
        tok_store = tok_scored;
        tok_store.valid = tok_scored.valid & ~bypass_ws_i;
    end

    // Register the forwarded token; empty when nothing passes through.
    always_ff @(posedge clk) begin
        if (!rst_n)
            fwd_q <= '0;
        else if (tok_scored.valid && bypass_ws_i)
            fwd_q <= tok_scored;
        else
            fwd_q <= '0;
    end

    tok_result u_res (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (clear_i),
        .cand_i  (tok_store),
        .best_o  (best_t)
    );

    // Drive the flat output ports.
    always_comb begin
        fwd_valid  = fwd_q.valid;
        fwd_len    = fwd_q.len;
        fwd_gap    = fwd_q.gap;
        best_valid = best_t.valid;
        best_len   = best_t.len;
        best_gap   = best_t.gap;
    end

    // R8: an open bypass never forwards.
    a_r8_no_fwd_open: assert property (@(posedge clk) disable iff (!rst_n)
        !bypass_ws_i |=> !fwd_valid);

    // R8: a closed bypass leaves the held result untouched.
    a_r8_store_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (bypass_ws_i && !clear_i) |=> $stable(best_t));

    // R11: no arrival, no forward.
    a_r11_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_valid && !e_valid) |=> !fwd_valid);

    // R2: a lone South token through a matching cell gains one Length.
    a_r2_len_step: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && !e_valid && bypass_ws_i && match_i && (s_len != LEN_MAX))
        |=> (fwd_valid && fwd_len == $past(s_len) + 1'b1));

    // R4: Length at the top stays at the top.
    a_r4_len_sat: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && !e_valid && bypass_ws_i && match_i && (s_len == LEN_MAX))
        |=> (fwd_len == LEN_MAX));

    // R5: the longer East token wins over a shorter South token.
    a_r5_longer_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && e_valid && bypass_ws_i && !match_i && !gap_i && (e_len > s_len))
        |=> (fwd_len == $past(e_len) && fwd_gap == $past(e_gap)));
endmodule

// File: tb/lcs_gap_cell_tb_top.sv
`timescale 1ns/1ps
module lcs_gap_cell_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       s_valid = 1'b0, e_valid = 1'b0;
    logic [7:0] s_len = '0, s_gap = '0, e_len = '0, e_gap = '0;
    logic       match_i = 1'b0, gap_i = 1'b0, bypass_ws_i = 1'b0, clear_i = 1'b0;
    logic       fwd_valid, best_valid;
    logic [7:0] fwd_len, fwd_gap, best_len, best_gap;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    lcs_gap_cell dut_i (
        .clk(clk), .rst_n(rst_n),
        .s_valid(s_valid), .s_len(s_len), .s_gap(s_gap),
        .e_valid(e_valid), .e_len(e_len), .e_gap(e_gap),
        .match_i(match_i), .gap_i(gap_i), .bypass_ws_i(bypass_ws_i), .clear_i(clear_i),
        .fwd_valid(fwd_valid), .fwd_len(fwd_len), .fwd_gap(fwd_gap),
        .best_valid(best_valid), .best_len(best_len), .best_gap(best_gap)
    );

    // Vector: sv sl sg | ev el eg | m g | tag | exp fv fl fg  (bypass closed)
    localparam int NV = 11;
    localparam logic [56:0] VEC [0:NV-1] = '{
        {1'b1,8'd5,8'd2,    1'b0,8'd0,8'd0,    1'b1,1'b0, 4'd2, 1'b1,8'd6,8'd2},    // R2 match adds
        {1'b1,8'd5,8'd2,    1'b0,8'd0,8'd0,    1'b0,1'b0, 4'd2, 1'b1,8'd5,8'd2},    // R2 no match
        {1'b0,8'd0,8'd0,    1'b1,8'd3,8'd4,    1'b0,1'b1, 4'd3, 1'b1,8'd3,8'd5},    // R3 gap adds
        {1'b1,8'd2,8'd2,    1'b1,8'd3,8'd1,    1'b0,1'b0, 4'd5, 1'b1,8'd3,8'd1},    // R5 East longer
        {1'b1,8'd7,8'd0,    1'b1,8'd4,8'd0,    1'b1,1'b0, 4'd5, 1'b1,8'd8,8'd0},    // R5 South longer
        {1'b1,8'd4,8'd3,    1'b1,8'd4,8'd1,    1'b0,1'b0, 4'd6, 1'b1,8'd4,8'd1},    // R6 fewer gaps East
        {1'b1,8'd4,8'd1,    1'b1,8'd4,8'd3,    1'b0,1'b1, 4'd6, 1'b1,8'd4,8'd2},    // R6 fewer gaps South
        {1'b1,8'd255,8'd0,  1'b0,8'd0,8'd0,    1'b1,1'b0, 4'd4, 1'b1,8'd255,8'd0},  // R4 Length saturates
        {1'b0,8'd0,8'd0,    1'b1,8'd10,8'd255, 1'b0,1'b1, 4'd4, 1'b1,8'd10,8'd255}, // R4 Gap saturates
        {1'b0,8'd9,8'd9,    1'b0,8'd9,8'd9,    1'b1,1'b1, 4'd11,1'b0,8'd0,8'd0},    // R11 idle
        {1'b1,8'd2,8'd0,    1'b0,8'd9,8'd0,    1'b0,1'b0, 4'd7, 1'b1,8'd2,8'd0}     // R7 invalid East ignored
    };

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Drive one cycle at a falling edge, then advance to the next falling edge.
    task automatic drive(input logic sv, input logic [7:0] sl, input logic [7:0] sg,
                         input logic ev, input logic [7:0] el, input logic [7:0] eg,
                         input logic m, input logic g, input logic byp, input logic clr);
        s_valid = sv; s_len = sl; s_gap = sg;
        e_valid = ev; e_len = el; e_gap = eg;
        match_i = m; gap_i = g; bypass_ws_i = byp; clear_i = clr;
        @(negedge clk);
        s_valid = 1'b0; e_valid = 1'b0; clear_i = 1'b0;
    endtask

    task automatic chk_best(input string req, input logic v, input int l, input int g);
        chk(req, "best_valid", int'(best_valid), int'(v));
        if (v) begin
            chk(req, "best_len", int'(best_len), l);
            chk(req, "best_gap", int'(best_gap), g);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog all-requirements: actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1", "fwd_valid in reset", int'(fwd_valid), 0);
        chk("R1", "best_valid in reset", int'(best_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "fwd_len", int'(fwd_len), 0);
        chk("R1", "best_len", int'(best_len), 0);

        // Vector walk with bypass closed (forward path).
        for (int i = 0; i < NV; i++) begin
            logic [56:0] v;
            v = VEC[i];
            drive(v[56], v[55:48], v[47:40], v[39], v[38:31], v[30:23],
                  v[22], v[21], 1'b1, 1'b0);
            chk($sformatf("R%0d", v[20:17]), $sformatf("vec%0d fwd_valid", i),
                int'(fwd_valid), int'(v[16]));
            if (v[16]) begin
                chk($sformatf("R%0d", v[20:17]), $sformatf("vec%0d fwd_len", i),
                    int'(fwd_len), int'(v[15:8]));
                chk($sformatf("R%0d", v[20:17]), $sformatf("vec%0d fwd_gap", i),
                    int'(fwd_gap), int'(v[7:0]));
            end
            chk("R8", $sformatf("vec%0d store untouched", i), int'(best_valid), 0);
        end

        // R8: open bypass stores, no forward.
        drive(1'b1, 8'd3, 8'd1, 1'b0, 8'd0, 8'd0, 1'b1, 1'b0, 1'b0, 1'b0);
        chk("R8", "no forward when open", int'(fwd_valid), 0);
        chk_best("R8", 1'b1, 4, 1);

        // R9: a weaker token is not stored.
        drive(1'b1, 8'd2, 8'd0, 1'b0, 8'd0, 8'd0, 1'b0, 1'b0, 1'b0, 1'b0);
        chk_best("R9", 1'b1, 4, 1);
        // R9: equal Length, fewer gaps replaces.
        drive(1'b0, 8'd0, 8'd0, 1'b1, 8'd4, 8'd0, 1'b0, 1'b0, 1'b0, 1'b0);
        chk_best("R9", 1'b1, 4, 0);

        // R8: forwarded token leaves the store alone.
        drive(1'b1, 8'd9, 8'd0, 1'b0, 8'd0, 8'd0, 1'b0, 1'b0, 1'b1, 1'b0);
        chk("R8", "forward when closed", int'(fwd_valid), 1);
        chk_best("R8", 1'b1, 4, 0);

        // R10: clear alone empties.
        drive(1'b0, 8'd0, 8'd0, 1'b0, 8'd0, 8'd0, 1'b0, 1'b0, 1'b0, 1'b1);
        chk_best("R10", 1'b0, 0, 0);

        // R10: clear with a weak stored arrival loads the weak token.
        drive(1'b1, 8'd6, 8'd6, 1'b0, 8'd0, 8'd0, 1'b0, 1'b0, 1'b0, 1'b0);
        chk_best("R10", 1'b1, 6, 6);
        drive(1'b1, 8'd1, 8'd0, 1'b0, 8'd0, 8'd0, 1'b0, 1'b0, 1'b0, 1'b1);
        chk_best("R10", 1'b1, 1, 0);

        // R1: reset mid-run clears everything.
        drive(1'b1, 8'd7, 8'd7, 1'b0, 8'd0, 8'd0, 1'b0, 1'b0, 1'b1, 1'b0);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1", "fwd_valid after reset", int'(fwd_valid), 0);
        chk("R1", "best_valid after reset", int'(best_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule